// File: doc/BRIEF.md
# Multiplexed Byte-Bus Register Target

This block sits behind an 8-bit multiplexed parallel bus driven by a slow, software-timed master. The master controls four lines: a strobe, an address-latch flag, a direction flag and a chip-select. The target recovers each bus phase from the rising edge of the strobe. An address phase loads an 8-bit register index. Each value phase then moves one byte of a 16-bit register, high byte first. Writes reach a small internal bank of 16-bit registers only when both bytes are present. Reads place the two bytes of the selected register on the data lines, one byte per strobe.

A transaction ends when the master raises chip-select. At each such rising edge the target answers on its ready output: low means done and high means retry. A stall count, sampled at every address phase, makes the target answer "retry" for that many end-of-transaction checks. This drives the master's retry paths. On a read, the master repeats both value phases after each retry. On a write, it toggles chip-select until ready falls. All bus inputs pass through two-flop synchronizers before any edge is detected.

Top module: `pbus_reg_target`

## Requirements
- R1: After reset, ready is 0, the data output enable is 0 and every register in the bank reads as 0x0000.
- R2: A strobe rising edge with the address-latch flag high latches the data byte as the register index, returns the byte order to the high byte and sets ready to 1.
- R3: With direction 1 and the address-latch flag low, the first strobe after an address phase carries bits 15:8 and the second carries bits 7:0. The register is written, as one 16-bit word, only when the second byte arrives.
- R4: A write that has received only its high byte is discarded when the next address phase begins, and the register keeps its old value.
- R5: With direction 0 and the address-latch flag low, the first strobe after an address phase makes the target present bits 15:8 of the selected register, and the next strobe makes it present bits 7:0.
- R6: The data output enable is 1 only during a read value phase (strobe high, direction 0, address-latch flag low). It is 0 during address phases, during write value phases and while strobe is low.
- R7: At each chip-select rising edge, ready stays 1 while stall checks remain, and each such edge uses up one check. Once no checks remain, ready falls to 0, unless a write is still waiting for its low byte.
- R8: A read retried by a stalled check restarts at the high byte, so every read attempt returns the full word with the high byte first.
- R9: Register indexes at or above the bank size (8) read as 0x0000, and writes to them change no register.
- R10: A strobe held high counts as exactly one phase. A new phase is accepted only after strobe has been seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data_in | input | 8 | Data lines as seen from the bus |
| bus_data_out | output | 8 | Byte presented during read value phases |
| bus_data_oe | output | 1 | Output enable for the data lines |
| bus_strobe | input | 1 | Phase strobe; a rising edge starts a phase |
| bus_ale | input | 1 | 1 marks an address phase |
| bus_dir | input | 1 | 1 for write, 0 for read |
| bus_cs | input | 1 | Chip-select; a rising edge is an end-of-transaction check |
| bus_ready | output | 1 | 0 means done, 1 means retry |
| stall_cfg | input | 4 | Number of checks answered with retry, sampled at each address phase |

## Verification
A byte-order error, or a byte index left at the wrong value, shows up as a swapped or duplicated byte in the very next word read back through the bus. Stall-count and commit errors show up at the ports as a wrong number of chip-select checks before ready falls. A stale partial write shows up as a corrupted register on the next read of that index. An output enable left on during an address or write phase can be seen directly at the next sample of the enable pin, within a few cycles of the strobe edge.

// File: rtl/pbus_tgt_pkg.sv
package pbus_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // Select a byte of a word: lo_sel = 0 gives the high byte.
  function automatic logic [BYTE_W-1:0] word_byte(input logic [WORD_W-1:0] w,
                                                   input logic lo_sel);
    return lo_sel ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pbus_phase_detect.sv
module pbus_phase_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_s,
  input  logic ale_s,
  input  logic dir_s,
  input  logic cs_s,
  output logic addr_evt,
  output logic wr_evt,
  output logic rd_evt,
  output logic stb_fall,
  output logic cs_rise
);
  logic stb_d, cs_d, stb_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d <= 1'b0;
      cs_d  <= 1'b0;
    end else begin
      stb_d <= stb_s;
      cs_d  <= cs_s;
    end
  end

  assign stb_rise = stb_s & ~stb_d;
  assign stb_fall = ~stb_s & stb_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign addr_evt = stb_rise & ale_s;
  assign wr_evt   = stb_rise & ~ale_s & dir_s;
  assign rd_evt   = stb_rise & ~ale_s & ~dir_s;
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
  import pbus_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int REG_AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [WORD_W-1:0] bank [NUM_REGS];
  logic              hit;
  logic [REG_AW-1:0] slot;

  assign hit  = (addr < ADDR_W'(NUM_REGS));
  assign slot = addr[REG_AW-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[i] <= '0;
      else if (we && hit && slot == REG_AW'(i))
        bank[i] <= wdata;
    end
  end

  assign rdata = hit ? bank[slot] : '0;
endmodule

// File: rtl/pbus_txn_ctrl.sv
module pbus_txn_ctrl
  import pbus_tgt_pkg::*;
#(
  parameter int STALL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTE_W-1:0]  din_s,
  input  logic               dir_s,
  input  logic               ale_s,
  input  logic               addr_evt,
  input  logic               wr_evt,
  input  logic               rd_evt,
  input  logic               stb_fall,
  input  logic               cs_rise,
  input  logic [STALL_W-1:0] stall_cfg,
  input  logic [WORD_W-1:0]  rf_rdata,
  output logic [BYTE_W-1:0]  rf_addr,
  output logic               rf_we,
  output logic [WORD_W-1:0]  rf_wdata,
  output logic [BYTE_W-1:0]  dout,
  output logic               oe,
  output logic               ready
);
  logic               lo_next;    // 0: next byte is the high byte
  logic               hi_have;    // high byte of a write is waiting
  logic [BYTE_W-1:0]  hi_q;
  logic [STALL_W-1:0] stall_left;
  logic               oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_addr    <= '0;
      rf_we      <= 1'b0;
      rf_wdata   <= '0;
      dout       <= '0;
      oe_q       <= 1'b0;
      ready      <= 1'b0;
      lo_next    <= 1'b0;
      hi_have    <= 1'b0;
      hi_q       <= '0;
      stall_left <= '0;
    end else begin
      rf_we <= 1'b0;
      if (addr_evt) begin
        rf_addr    <= din_s;
        lo_next    <= 1'b0;
        hi_have    <= 1'b0;
        stall_left <= stall_cfg;
        ready      <= 1'b1;
        oe_q       <= 1'b0;
      end else if (wr_evt) begin
        if (!lo_next) begin
          hi_q    <= din_s;
          hi_have <= 1'b1;
          lo_next <= 1'b1;
        end else begin
          rf_we    <= 1'b1;
          rf_wdata <= join_bytes(hi_q, din_s);
          hi_have  <= 1'b0;
          lo_next  <= 1'b0;
        end
      end else if (rd_evt) begin
        dout    <= word_byte(rf_rdata, lo_next);
        lo_next <= ~lo_next;
        oe_q    <= 1'b1;
      end
      if (stb_fall)
        oe_q <= 1'b0;
      if (cs_rise) begin
        if (stall_left != '0) begin
          stall_left <= stall_left - STALL_W'(1);
          ready      <= 1'b1;
          if (!dir_s)
            lo_next <= 1'b0;
        end else begin
          ready <= hi_have;
        end
      end
    end
  end

  assign oe = oe_q & ~dir_s & ~ale_s;
endmodule

// File: rtl/pbus_reg_target.sv
module pbus_reg_target
  import pbus_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int STALL_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         bus_data_in,
  output logic [7:0]         bus_data_out,
  output logic               bus_data_oe,
  input  logic               bus_strobe,
  input  logic               bus_ale,
  input  logic               bus_dir,
  input  logic               bus_cs,
  output logic               bus_ready,
  input  logic [STALL_W-1:0] stall_cfg
);
  localparam int CTL_W = 4;

  logic [BYTE_W-1:0] din_s;
  logic [CTL_W-1:0]  ctl_s;
  logic stb_s, ale_s, dir_s, cs_s;
  logic addr_evt, wr_evt, rd_evt, stb_fall, cs_rise;
  logic [BYTE_W-1:0] rf_addr;
  logic              rf_we;
  logic [WORD_W-1:0] rf_wdata, rf_rdata;

  pbus_sync #(.W(BYTE_W)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(bus_data_in), .q(din_s)
  );
  pbus_sync #(.W(CTL_W)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d({bus_strobe, bus_ale, bus_dir, bus_cs}), .q(ctl_s)
  );
  assign {stb_s, ale_s, dir_s, cs_s} = ctl_s;

  pbus_phase_detect u_detect (
    .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .ale_s(ale_s), .dir_s(dir_s),
    .cs_s(cs_s), .addr_evt(addr_evt), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .stb_fall(stb_fall), .cs_rise(cs_rise)
  );

  pbus_txn_ctrl #(.STALL_W(STALL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .din_s(din_s), .dir_s(dir_s), .ale_s(ale_s),
    .addr_evt(addr_evt), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .stb_fall(stb_fall), .cs_rise(cs_rise), .stall_cfg(stall_cfg),
    .rf_rdata(rf_rdata), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .dout(bus_data_out), .oe(bus_data_oe),
    .ready(bus_ready)
  );

  pbus_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(rf_addr), .we(rf_we),
    .wdata(rf_wdata), .rdata(rf_rdata)
  );
endmodule

// File: rtl/pbus_reg_target_chk.sv
module pbus_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_evt,
  input logic wr_evt,
  input logic rd_evt,
  input logic cs_rise,
  input logic rf_we,
  input logic bus_ready,
  input logic bus_data_oe
);
  assert_single_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_evt, wr_evt, rd_evt}));

  assert_commit_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(wr_evt));

  assert_oe_from_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_data_oe) |-> $past(rd_evt));

  assert_ready_falls_on_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ready) |-> $past(cs_rise));

  assert_ready_rises_on_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ready) |-> $past(addr_evt));
endmodule

bind pbus_reg_target pbus_reg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_evt(addr_evt), .wr_evt(wr_evt),
  .rd_evt(rd_evt), .cs_rise(cs_rise), .rf_we(rf_we),
  .bus_ready(bus_ready), .bus_data_oe(bus_data_oe)
);

// File: tb/pbus_reg_target_bench.sv
module pbus_reg_target_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] m_data = '0;
  logic       m_stb = 1'b0, m_ale = 1'b0, m_dir = 1'b0, m_cs = 1'b0;
  logic [3:0] m_stall = '0;
  logic [7:0] t_dout;
  logic       t_oe, t_ready;

  int applied = 0;
  int miscmp  = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] obs_q[$];

  always #10 clk = ~clk;

  pbus_reg_target u_pbus_reg_target (
    .clk(clk), .rst_n(rst_n), .bus_data_in(m_data), .bus_data_out(t_dout),
    .bus_data_oe(t_oe), .bus_strobe(m_stb), .bus_ale(m_ale), .bus_dir(m_dir),
    .bus_cs(m_cs), .bus_ready(t_ready), .stall_cfg(m_stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_bus();
    m_data = '0; m_cs = 1'b0; m_stb = 1'b0; m_ale = 1'b0;
    step();
  endtask

  task automatic addr_phase(input logic [7:0] a);
    clear_bus();
    m_ale = 1'b1; m_data = a; step();
    m_stb = 1'b1; step();
  endtask

  task automatic wr_byte(input logic [7:0] b);
    clear_bus();
    m_data = b; m_stb = 1'b1; step();
  endtask

  task automatic m_write(input logic [7:0] a, input logic [15:0] v, output int polls);
    m_dir = 1'b1;
    addr_phase(a);
    wr_byte(v[15:8]);
    wr_byte(v[7:0]);
    m_cs = 1'b1; step();
    polls = 0;
    while (t_ready && polls < 40) begin
      m_cs = 1'b0; step();
      m_cs = 1'b1; step();
      polls++;
    end
  endtask

  // Driver: pushes the expected word, then runs the read; the observed
  // word of the final attempt goes to the monitor.
  task automatic m_read(input logic [7:0] a, input logic [15:0] exp, input string tag,
                        output int attempts, output bit hi_first_ok);
    logic [15:0] w;
    exp_q.push_back(exp); tag_q.push_back(tag);
    m_dir = 1'b0;
    addr_phase(a);
    attempts = 0; hi_first_ok = 1'b1;
    do begin
      w = '0;
      for (int i = 1; i >= 0; i--) begin
        clear_bus();
        m_stb = 1'b1; step();
        if (!t_oe) hi_first_ok = 1'b0;
        w[i*8 +: 8] = t_dout;
      end
      if (w != exp) hi_first_ok = 1'b0;
      m_cs = 1'b1; step();
      attempts++;
    end while (t_ready && attempts < 40);
    obs_q.push_back(w);
  endtask

  // Monitor: compares observed words against the scoreboard queue.
  initial begin
    forever begin
      wait (obs_q.size() != 0);
      begin
        logic [15:0] o, e;
        string t;
        o = obs_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        check(o == e, t, int'(o), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    int  n;
    bit  ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(t_ready == 1'b0, "R1 ready after reset", int'(t_ready), 0);
    check(t_oe == 1'b0, "R1 oe after reset", int'(t_oe), 0);
    m_read(8'd0, 16'h0000, "R1 reg0 reset value", n, ok);
    m_read(8'd7, 16'h0000, "R1 reg7 reset value", n, ok);

    // R2 ready high after address phase, R6 oe low in address phase
    m_dir = 1'b1;
    addr_phase(8'd1);
    check(t_ready == 1'b1, "R2 ready after address phase", int'(t_ready), 1);
    check(t_oe == 1'b0, "R6 oe during address phase", int'(t_oe), 0);
    wr_byte(8'hA5);
    check(t_oe == 1'b0, "R6 oe during write byte", int'(t_oe), 0);
    // R10 holding strobe high: still only one byte taken
    repeat (20) @(negedge clk);
    wr_byte(8'h5A);
    m_cs = 1'b1; step();
    check(t_ready == 1'b0, "R7 ready after write check", int'(t_ready), 0);
    m_read(8'd1, 16'hA55A, "R10 R3 word after held strobe", n, ok);

    // R3 / R5 several patterns
    m_write(8'd2, 16'h1234, n);
    m_write(8'd4, 16'hFFFF, n);
    m_write(8'd6, 16'h0001, n);
    m_read(8'd2, 16'h1234, "R3 reg2", n, ok);
    m_read(8'd4, 16'hFFFF, "R3 reg4", n, ok);
    m_read(8'd6, 16'h0001, "R3 reg6", n, ok);

    // R5 high byte presented first, R6 oe high during read value phase
    m_dir = 1'b0;
    addr_phase(8'd2);
    clear_bus();
    check(t_oe == 1'b0, "R6 oe with strobe low", int'(t_oe), 0);
    m_stb = 1'b1; step();
    check(t_oe == 1'b1, "R6 oe in read phase", int'(t_oe), 1);
    check(t_dout == 8'h12, "R5 first read byte", int'(t_dout), 'h12);
    clear_bus();
    m_stb = 1'b1; step();
    check(t_dout == 8'h34, "R5 second read byte", int'(t_dout), 'h34);
    m_cs = 1'b1; step();
    check(t_ready == 1'b0, "R7 read done", int'(t_ready), 0);

    // R4 partial write discarded
    m_write(8'd3, 16'h1111, n);
    m_dir = 1'b1;
    addr_phase(8'd3);
    wr_byte(8'h99);
    m_write(8'd5, 16'h2222, n);
    m_read(8'd3, 16'h1111, "R4 reg3 after partial", n, ok);
    m_read(8'd5, 16'h2222, "R4 reg5 after partial", n, ok);

    // R7 write stall
    m_stall = 4'd3;
    m_write(8'd0, 16'hC0DE, n);
    check(n == 3, "R7 write polls with stall 3", n, 3);
    // R8 read retry with stall
    m_stall = 4'd2;
    m_read(8'd0, 16'hC0DE, "R8 word after retries", n, ok);
    check(n == 3, "R8 read attempts with stall 2", n, 3);
    check(ok, "R8 each attempt high byte first", int'(ok), 1);
    m_stall = 4'd0;

    // R9 out-of-range index
    m_write(8'd10, 16'hBEEF, n);
    m_read(8'd10, 16'h0000, "R9 index 10 reads zero", n, ok);
    m_read(8'd2, 16'h1234, "R9 alias reg2 untouched", n, ok);
    m_read(8'd6, 16'h0001, "R9 reg6 untouched", n, ok);

    wait (obs_q.size() == 0);
    step();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end
endmodule